// File: doc/BRIEF.md
# Serial Receiver with Per-Character Status Bytes

This block receives asynchronous serial characters on a single line and turns each one into writes on a byte-wide FIFO port. It runs from the system clock and takes a one-cycle enable pulse at sixteen times the bit rate. On each pulse it samples the line, confirms a start bit, shifts in five to nine data bits least significant bit first, checks an optional parity bit and the stop bit, and recognises a line that is held low as a break.

In normal mode each character produces one FIFO write that carries the data. Any parity, framing, overrun or break information is dropped. In wide mode each character produces two writes on consecutive cycles. The first is the data byte. The second is a status byte that holds the error flags, the break flag, and the ninth data bit, which multidrop links use to tell addresses from data. The block does not write a character unless the FIFO has room for all of the bytes that character needs. When it has to drop a character, it marks the next character it does store with an overrun flag.

Top module: `uart_rx_status`

## Requirements
- R1: A character is a low start bit followed by N data bits sent least significant bit first, where N = 5 + `len_sel_i` (00→5, 11→8). The data byte written holds the received bits in bits N-1..0, and its upper bits are zero.
- R2: When `nine_bit_i` is 1, a character carries 9 data bits and no parity bit. The data byte holds bits 7..0, and bit 8 is delivered only in the wide-mode status byte.
- R3: When `par_en_i` is 1 and `nine_bit_i` is 0, a parity bit follows the data. The expected parity bit is the XOR of the data bits, inverted when `par_odd_i` is 1. A mismatch sets the parity-error flag.
- R4: In normal mode (`wide_i` = 0), each stored character gives exactly one write, which is the data byte, and all status is discarded.
- R5: In wide mode, each stored character gives a write of the data byte followed on the next cycle by a write of the status byte. The status byte has bit0 = ninth data bit, bit1 = parity error, bit2 = framing error, bit3 = overrun, bit4 = break, and bits 7..5 = 0.
- R6: If the stop bit is sampled low, the framing-error flag is set. The receiver then looks for no new start bit until the line has returned high.
- R7: A character whose data bits, parity bit (if present) and stop bit are all low sets the break flag and is stored with data 0x00. Only one character is stored for each continuous low period of the line.
- R8: The line is sampled again in the middle of the start bit, and a start bit that is high at that point is rejected with no write.
- R9: A character is stored only if there is room for it. Normal mode needs `fifo_full_i` = 0. Wide mode needs `fifo_last_i` = 0, where `fifo_last_i` means fewer than two free slots. Otherwise the character is dropped and causes no write.
- R10: After a character has been dropped, the next character that is stored carries the overrun flag. The flag is then cleared.
- R11: After reset the receiver is idle and makes no writes while the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| len_sel_i | input | 2 | Data length select, 5 + value bits |
| nine_bit_i | input | 1 | Nine data bits, no parity |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| wide_i | input | 1 | Append a status byte to each character |
| fifo_full_i | input | 1 | FIFO has no free slot |
| fifo_last_i | input | 1 | FIFO has fewer than two free slots |
| fifo_we_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | 8 | FIFO write data |

## Verification
The interaction of most interest is one status byte that reports two unrelated events: an overrun left over from an earlier dropped character, and a break or framing error in the current character. The bench provokes this on purpose. It holds `fifo_last_i` high during one wide-mode character so that the character is dropped, and then sends a break. The bench model expects the overrun, framing and break bits together in the status byte that follows, and expects exactly one stored character for the whole low period. Random frames then mix bad parity bits, low stop bits, full flags and lengths. Every write is compared in order against a queue that the bench functions fill.

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  input  logic       tick_i,
  input  logic [1:0] len_sel_i,
  input  logic       nine_bit_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       wide_i,
  input  logic       fifo_full_i,
  input  logic       fifo_last_i,
  output logic       fifo_we_o,
  output logic [7:0] fifo_wdata_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAIT} st_t;
  st_t st;

  logic          rx_m, rx_s;
  logic [CW-1:0] cnt;
  logic [3:0]    bidx;
  logic [8:0]    sh;
  logic          par_bit;
  logic          ovr_q;
  logic          stat_pend, is_stat_q, we_q;
  logic [7:0]    wd_q, stat_q;

  logic [3:0] nbits;
  logic       par_use;
  logic [8:0] aligned;
  logic       pe, fe, brk, room, samp;

  assign nbits    = nine_bit_i ? 4'd9 : 4'd5 + {2'b00, len_sel_i};
  assign par_use  = par_en_i & ~nine_bit_i;
  assign aligned  = sh >> (4'd9 - nbits);
  assign pe       = par_use & ((^aligned) ^ par_odd_i ^ par_bit);
  assign fe       = ~rx_s;
  assign brk      = (aligned == 9'd0) & ~(par_use & par_bit) & ~rx_s;
  assign room     = wide_i ? ~fifo_last_i : ~fifo_full_i;
  assign samp     = tick_i && (cnt == LAST);

  assign fifo_we_o    = we_q;
  assign fifo_wdata_o = wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_i;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      sh      <= '0;
      par_bit <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (!rx_s) st <= S_START;
        end
        S_START: if (tick_i) begin
          if (cnt == MID) begin
            cnt  <= '0;
            bidx <= '0;
            st   <= rx_s ? S_IDLE : S_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: if (tick_i) begin
          cnt <= cnt + 1'b1;
          if (samp) begin
            sh   <= {rx_s, sh[8:1]};
            bidx <= bidx + 4'd1;
            if (bidx == nbits - 4'd1) st <= par_use ? S_PAR : S_STOP;
          end
        end
        S_PAR: if (tick_i) begin
          cnt <= cnt + 1'b1;
          if (samp) begin
            par_bit <= rx_s;
            st      <= S_STOP;
          end
        end
        S_STOP: if (tick_i) begin
          cnt <= cnt + 1'b1;
          if (samp) st <= rx_s ? S_IDLE : S_WAIT;
        end
        S_WAIT: if (rx_s) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q      <= 1'b0;
      wd_q      <= '0;
      stat_q    <= '0;
      stat_pend <= 1'b0;
      is_stat_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      we_q      <= stat_pend;
      is_stat_q <= stat_pend;
      stat_pend <= 1'b0;
      if (stat_pend) wd_q <= stat_q;
      if (st == S_STOP && samp) begin
        if (room) begin
          we_q      <= 1'b1;
          is_stat_q <= 1'b0;
          wd_q      <= aligned[7:0];
          stat_pend <= wide_i;
          stat_q    <= {3'b000, brk, ovr_q, fe, pe, aligned[8] & nine_bit_i};
          ovr_q     <= 1'b0;
        end else begin
          ovr_q <= 1'b1;
        end
      end
    end
  end

  p_room_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_we_o && !is_stat_q) |-> $past(!fifo_full_i));

  p_status_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_we_o && is_stat_q) |-> $past(fifo_we_o && !is_stat_q));

  p_status_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_we_o && is_stat_q) |-> (fifo_wdata_o[7:5] == 3'b000));

  p_normal_no_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_we_o && is_stat_q) |-> $past(wide_i, 2));

  p_one_break_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && $past(st == S_WAIT)) |-> !(fifo_we_o && !is_stat_q));

  p_glitch_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && tick_i && cnt == MID && rx_s) |=> (st == S_IDLE && !(fifo_we_o && !is_stat_q)));

  p_wait_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !rx_s) |=> (st == S_WAIT));
endmodule

// File: tb/uart_rx_status_test.sv
module uart_rx_status_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic tick = 1'b0;
  logic [1:0] len_sel = 2'd3;
  logic nine = 1'b0, par_en = 1'b0, par_odd = 1'b0, wide = 1'b0;
  logic full = 1'b0, last = 1'b0;
  logic fifo_we;
  logic [7:0] fifo_wdata;

  int checks = 0, errors = 0, writes = 0, tc = 0;
  bit ovr_model = 1'b0;
  bit done = 1'b0;
  logic [7:0] expq[$];
  string tagq[$];

  localparam int BITC = 48;

  always #2.5 clk = ~clk;

  uart_rx_status uut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick),
    .len_sel_i(len_sel), .nine_bit_i(nine), .par_en_i(par_en), .par_odd_i(par_odd),
    .wide_i(wide), .fifo_full_i(full), .fifo_last_i(last),
    .fifo_we_o(fifo_we), .fifo_wdata_o(fifo_wdata)
  );

  initial forever begin
    @(negedge clk);
    tick = (tc == 0);
    tc = (tc == 2) ? 0 : tc + 1;
  end

  always @(negedge clk) if (fifo_we && !done) begin
    writes++;
    checks++;
    if (expq.size() == 0) begin
      errors++;
      $display("FAIL R4/R5 unexpected write got %02h exp none", fifo_wdata);
    end else begin
      logic [7:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      if (fifo_wdata !== e) begin
        errors++;
        $display("FAIL %s got %02h exp %02h", t, fifo_wdata, e);
      end
    end
  end

  function automatic int nb_of();
    return nine ? 9 : 5 + int'(len_sel);
  endfunction

  function automatic bit exp_par(logic [8:0] d);
    bit p = par_odd;
    for (int i = 0; i < nb_of(); i++) p ^= d[i];
    return p;
  endfunction

  task automatic check(bit ok, string tag, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic bitw(logic lvl);
    rx = lvl;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic frame(logic [8:0] d, bit bad_par, bit stop_lvl, int hold_low);
    int nb = nb_of();
    bit pu = par_en && !nine;
    bit pbit, pe, fe, brk, room;
    logic [8:0] dm;
    dm = d & ((9'h1 << nb) - 9'h1);
    pbit = exp_par(dm) ^ bad_par;
    if (dm == 0 && !stop_lvl && pu) pbit = 1'b0;
    pe = pu && (pbit != exp_par(dm));
    fe = !stop_lvl;
    brk = (dm == 0) && !(pu && pbit) && !stop_lvl;
    room = wide ? !last : !full;
    if (room) begin
      expq.push_back(dm[7:0]);
      tagq.push_back(nine ? "R2 data" : (wide ? "R1 data" : "R4 data"));
      if (wide) begin
        expq.push_back({3'b000, brk, ovr_model, fe, pe, nine & dm[8]});
        tagq.push_back($sformatf("R5%s%s%s%s", pe ? " R3" : "", fe ? " R6" : "",
                                 ovr_model ? " R10" : "", brk ? " R7" : ""));
      end
      ovr_model = 1'b0;
    end else begin
      ovr_model = 1'b1;
    end
    bitw(1'b0);
    for (int i = 0; i < nb; i++) bitw(dm[i]);
    if (pu) bitw(pbit);
    bitw(stop_lvl);
    if (hold_low > 0) repeat (hold_low) bitw(1'b0);
    bitw(1'b1);
    bitw(1'b1);
    check(expq.size() == 0, "R4/R9 entries outstanding", expq.size(), 0);
  endtask

  task automatic cfg(int ls, bit n9, bit pen, bit podd, bit wd);
    len_sel = 2'(ls); nine = n9; par_en = pen; par_odd = podd; wide = wd;
    full = 1'b0; last = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired got 1 exp 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int w0;
    void'($urandom(32'd1234));
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check(fifo_we == 1'b0 && writes == 0, "R11 idle after reset", writes, 0);

    cfg(3, 0, 0, 0, 0); frame(9'h0A5, 0, 1, 0);
    cfg(0, 0, 0, 0, 0); frame(9'h01F, 0, 1, 0);
    cfg(2, 0, 1, 0, 1); frame(9'h05A, 0, 1, 0);
    cfg(3, 0, 1, 1, 1); frame(9'h0C3, 1, 1, 0);
    cfg(1, 0, 1, 0, 1); frame(9'h02D, 1, 1, 0);
    cfg(0, 1, 1, 0, 1); frame(9'h1C3, 0, 1, 0);
    cfg(0, 1, 0, 0, 0); frame(9'h1C3, 0, 1, 0);
    cfg(3, 0, 0, 0, 1); frame(9'h081, 0, 0, 0);

    cfg(3, 0, 0, 0, 1);
    w0 = writes;
    rx = 1'b0; repeat (9) @(negedge clk);
    rx = 1'b1; repeat (3 * BITC) @(negedge clk);
    check(writes == w0, "R8 glitch produced writes", writes - w0, 0);

    cfg(3, 0, 0, 0, 1); last = 1'b1;
    w0 = writes;
    frame(9'h066, 0, 1, 0);
    check(writes == w0, "R9 dropped char wrote", writes - w0, 0);
    cfg(3, 0, 1, 0, 1);
    frame(9'h000, 0, 0, 30);

    cfg(2, 0, 0, 0, 0); full = 1'b1;
    frame(9'h011, 0, 1, 0);
    cfg(2, 0, 0, 0, 0);
    w0 = writes;
    frame(9'h000, 0, 0, 20);
    check(writes == w0 + 1, "R7 one write per break", writes - w0, 1);

    cfg(3, 0, 0, 0, 1); full = 1'b0; last = 1'b1;
    frame(9'h0AA, 0, 1, 0);
    cfg(3, 0, 0, 0, 0);
    frame(9'h055, 0, 1, 0);
    cfg(3, 0, 0, 0, 1);
    frame(9'h033, 0, 1, 0);

    for (int k = 0; k < 100; k++) begin
      int r, hl;
      bit bp, sl;
      logic [8:0] d;
      cfg($urandom % 4, ($urandom % 4) == 0, $urandom % 2, $urandom % 2, $urandom % 2);
      r = $urandom % 8;
      if (r == 0) begin full = 1'b1; last = 1'b1; end
      else if (r == 1) last = 1'b1;
      d = 9'($urandom);
      bp = ($urandom % 5) == 0;
      sl = ($urandom % 10) != 0;
      hl = 0;
      if (($urandom % 30) == 0) begin d = 9'h000; sl = 1'b0; hl = 12; end
      frame(d, bp, sl, hl);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule